// File: doc/BRIEF.md
# Port Change Interrupt Monitor

This block watches sixteen synchronized port levels, organised as two banks of eight, and signals an active-low interrupt whenever a port configured as an input no longer matches the level recorded for it. The recorded levels come from host reads. A single-cycle read strobe for a bank returns that bank's live pin levels on the read data bus and, at the same clock edge, stores them as the bank's new reference. From then on the live levels are compared with that reference, not with the level of the previous clock.

A pending change goes away in two ways. If the port returns to its reference level, the interrupt is released with no host action. If the host reads the bank, the reference moves to the current levels and the mismatch is gone. The two banks' pending conditions are ORed onto one interrupt line. When the line is not in interrupt mode, it carries a general output level instead. On the first clock after reset release, both references load the pins, so levels present during reset raise nothing.

Top module: `port_change_irq`

## Requirements
- R1: While reset is held, and in the cycle after release, `irq_n` is 1 when `irq_mode` is 1.
- R2: `rd_data` shows the live levels of the strobed bank, whether the ports are inputs or outputs: `pin_in[7:0]` for `bank_rd[0]`, `pin_in[15:8]` for `bank_rd[1]`. Bank 0 wins when both strobes are 1. With no strobe, `rd_data` is 0.
- R3: In interrupt mode, `irq_n` goes to 0 one clock after a monitored port (`port_is_in` bit = 1) differs from its reference.
- R4: Ports with `port_is_in` = 0 never cause an interrupt, however their levels change.
- R5: When a changed port returns to its reference level, `irq_n` goes back to 1 one clock later with no read.
- R6: A strobe on a bank clears that bank's pending condition at the strobe's clock edge, and the levels it returned become the new reference.
- R7: A strobe on one bank does not clear a change pending in the other bank.
- R8: With `irq_mode` = 0, `irq_n` equals `gpo_level` in the same cycle, whatever changes are pending.
- R9: `irq_n` is 0 while either bank has a pending change.
- R10: Pin levels present when reset is released become the reference, so they raise no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the system |
| pin_in | input | 16 | Synchronized port levels, bank 1 in the upper byte |
| port_is_in | input | 16 | Per-port direction, 1 = input (monitored) |
| bank_rd | input | 2 | Single-cycle read strobes, one per bank |
| rd_data | output | 8 | Live levels of the strobed bank |
| irq_mode | input | 1 | 1 = shared line carries the interrupt |
| gpo_level | input | 1 | Level driven on the shared line when not in interrupt mode |
| irq_n | output | 1 | Active-low interrupt or general output |

## Verification
The assertions take for granted that `pin_in` and `port_is_in` are already synchronous to `clk`, and that every read strobe lasts exactly one cycle and is a level, not an edge. The bench changes inputs only on the falling clock edge. It raises each strobe for a single cycle, and it leaves reset with defined pin values, so the capture that follows release sees stable data. A random phase keeps to the same rules, with mixed directions and occasional double strobes.

// File: rtl/pcd_pkg.sv
package pcd_pkg;
  localparam int unsigned PCD_BANKS  = 2;
  localparam int unsigned PCD_BANK_W = 8;
endpackage

// File: rtl/pcd_bank.sv
module pcd_bank #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         rd,
  input  logic [W-1:0] pins,
  input  logic [W-1:0] dir_in,
  output logic         pend
);
  logic [W-1:0] snap_q, snap_d;
  logic         snap_en;
  logic         pend_q, pend_d;

  always_comb begin
    snap_en = load | rd;
    snap_d  = snap_q;
    pend_d  = pend_q;
    if (snap_en) begin
      snap_d = pins;
      pend_d = 1'b0;
    end else begin
      pend_d = |((pins ^ snap_q) & dir_in);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q <= '0;
    end else if (snap_en) begin
      snap_q <= snap_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign pend = pend_q;

  // R10: reference load after reset leaves nothing pending
  p_prime_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !pend_q);
  // R6: a bank read clears its pending condition
  p_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> !pend_q);
  // R4: output ports never register a change
  p_outputs_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_in == '0) |=> !pend_q);
  // R6: the reference becomes the levels present at the read
  p_snap_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (load || rd) |=> (snap_q == $past(pins)));
  // R6: without a read the reference does not move
  p_snap_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(load || rd) |=> $stable(snap_q));
endmodule

// File: rtl/pcd_irq_out.sv
module pcd_irq_out #(
  parameter int unsigned BANKS = 2
) (
  input  logic [BANKS-1:0] pend,
  input  logic             irq_mode,
  input  logic             gpo_level,
  output logic             irq_n
);
  logic any_pend;

  always_comb begin
    any_pend = |pend;
    irq_n    = irq_mode ? ~any_pend : gpo_level;
  end
endmodule

// File: rtl/port_change_irq.sv
module port_change_irq
  import pcd_pkg::*;
#(
  parameter int unsigned BANKS  = PCD_BANKS,
  parameter int unsigned BANK_W = PCD_BANK_W,
  localparam int unsigned PORTS = BANKS * BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PORTS-1:0]  pin_in,
  input  logic [PORTS-1:0]  port_is_in,
  input  logic [BANKS-1:0]  bank_rd,
  output logic [BANK_W-1:0] rd_data,
  input  logic              irq_mode,
  input  logic              gpo_level,
  output logic              irq_n
);
  logic             primed_q, primed_d;
  logic [BANKS-1:0] bank_pend;
  logic             hit;

  always_comb primed_d = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         primed_q <= 1'b0;
    else if (!primed_q) primed_q <= primed_d;
  end

  always_comb begin
    rd_data = '0;
    hit     = 1'b0;
    for (int b = 0; b < int'(BANKS); b++) begin
      if (bank_rd[b] && !hit) begin
        rd_data = pin_in[b*BANK_W +: BANK_W];
        hit     = 1'b1;
      end
    end
  end

  for (genvar g = 0; g < int'(BANKS); g++) begin : g_bank
    pcd_bank #(.W(BANK_W)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (!primed_q),
      .rd     (bank_rd[g]),
      .pins   (pin_in[g*BANK_W +: BANK_W]),
      .dir_in (port_is_in[g*BANK_W +: BANK_W]),
      .pend   (bank_pend[g])
    );
  end

  pcd_irq_out #(.BANKS(BANKS)) u_out (
    .pend      (bank_pend),
    .irq_mode  (irq_mode),
    .gpo_level (gpo_level),
    .irq_n     (irq_n)
  );

  // R1: the line stays released until the first reference load is done
  p_release_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!primed_q && irq_mode) |=> irq_n);
endmodule

// File: tb/port_change_irq_test.sv
module port_change_irq_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] pin_in;
  logic [15:0] port_is_in;
  logic [1:0]  bank_rd;
  logic [7:0]  rd_data;
  logic        irq_mode;
  logic        gpo_level;
  logic        irq_n;

  always #10 clk = ~clk;

  port_change_irq uut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .port_is_in(port_is_in),
    .bank_rd(bank_rd), .rd_data(rd_data), .irq_mode(irq_mode),
    .gpo_level(gpo_level), .irq_n(irq_n)
  );

  typedef struct {
    logic       exp_irq;
    logic [7:0] exp_rd;
    string      tag;
  } item_t;

  item_t q[$];
  int    n_run  = 0;
  int    n_fail = 0;
  bit    done   = 0;

  // reference model state
  logic [15:0] m_snap;
  logic [1:0]  m_pend;
  bit          m_primed;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: called at a falling edge, drives one cycle and pushes expectations
  task automatic cyc(input logic [15:0] p, input logic [15:0] d, input logic [1:0] rd,
                     input logic mode, input logic gpo, input string tag);
    item_t it;
    pin_in = p; port_is_in = d; bank_rd = rd; irq_mode = mode; gpo_level = gpo;
    it.exp_rd = rd[0] ? p[7:0] : (rd[1] ? p[15:8] : 8'h00);
    if (!m_primed) begin
      m_snap = p; m_pend = 2'b00; m_primed = 1;
    end else begin
      for (int b = 0; b < 2; b++) begin
        if (rd[b]) begin
          m_snap[b*8 +: 8] = p[b*8 +: 8];
          m_pend[b] = 1'b0;
        end else begin
          m_pend[b] = |((p[b*8 +: 8] ^ m_snap[b*8 +: 8]) & d[b*8 +: 8]);
        end
      end
    end
    it.exp_irq = mode ? ~|m_pend : gpo;
    it.tag = tag;
    q.push_back(it);
    @(negedge clk);
  endtask

  // monitor: samples a quarter period after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        check({it.tag, " irq_n"}, {7'd0, irq_n}, {7'd0, it.exp_irq});
        check({it.tag, " rd_data"}, rd_data, it.exp_rd);
      end
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] p, d;
    logic [1:0]  r;
    m_primed = 0; m_pend = 0; m_snap = 0;
    rst_n = 1'b0; pin_in = 16'hA5C3; port_is_in = 16'hFFFF;
    bank_rd = 2'b00; irq_mode = 1'b1; gpo_level = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset irq_n", {7'd0, irq_n}, 8'h01);
    rst_n = 1'b1;
    cyc(16'hA5C3, 16'hFFFF, 2'b00, 1, 0, "R1 R10 prime");
    cyc(16'hA5C3, 16'hFFFF, 2'b00, 1, 0, "R10 no change");
    cyc(16'hA5C2, 16'hFFFF, 2'b00, 1, 0, "R3 bit0 change");
    cyc(16'hA5C3, 16'hFFFF, 2'b00, 1, 0, "R5 bit0 returns");
    cyc(16'hA7C3, 16'hFFFF, 2'b00, 1, 0, "R3 bit9 change");
    cyc(16'hA7C3, 16'hFFFF, 2'b01, 1, 0, "R7 read other bank");
    cyc(16'hA7C3, 16'hFFFF, 2'b10, 1, 0, "R6 R2 read bank1");
    cyc(16'hA7C3, 16'hFFFF, 2'b00, 1, 0, "R6 new reference");
    cyc(16'hA73C, 16'hFF00, 2'b00, 1, 0, "R4 outputs toggle");
    cyc(16'hA75A, 16'hFF00, 2'b01, 1, 0, "R2 R4 read output ports");
    cyc(16'h275A, 16'hFFFF, 2'b00, 1, 0, "R9 bank1 change");
    cyc(16'h275B, 16'hFFFF, 2'b00, 1, 0, "R9 both change");
    cyc(16'h275B, 16'hFFFF, 2'b01, 1, 0, "R9 read bank0 only");
    cyc(16'h275B, 16'hFFFF, 2'b00, 0, 0, "R8 gpo low");
    cyc(16'h275B, 16'hFFFF, 2'b00, 0, 1, "R8 gpo high pending");
    cyc(16'h275B, 16'hFFFF, 2'b11, 1, 0, "R2 both strobes");
    cyc(16'h275B, 16'hFFFF, 2'b00, 1, 0, "R2 R6 no strobe");
    for (int i = 0; i < 300; i++) begin
      p = pin_in ^ (16'(1) << ($urandom % 16)) ^ (($urandom % 4 == 0) ? 16'h0100 : 16'h0000);
      d = ($urandom % 3 == 0) ? 16'($urandom) : port_is_in;
      r = ($urandom % 5 == 0) ? 2'($urandom) : 2'b00;
      cyc(p, d, r, ($urandom % 8) != 0, 1'($urandom), "R3 R5 R9 random");
    end
    bank_rd = 2'b00;
    repeat (3) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule